// File: doc/BRIEF.md
# Configurable Keypad Matrix Scanner

The block scans a key matrix of up to 8 row lines by 10 column lines and turns key activity into a stream of one-cycle events. Each event carries a key number and a flag telling a press from a release. Rows are inputs with pull-ups. The scanner pulls one column at a time low, so a row that reads low marks a closed key at that crossing.

All 18 lines share one pin bus: rows occupy pins 0..NROW-1 and columns follow. Two enable vectors decide which rows and columns belong to the matrix. Every line left out behaves as a plain general-purpose pin, either an input or a driven output. A complete scan snapshot must stay unchanged for a debounce time, given in microseconds and converted to clock cycles from `CLK_HZ`, before it becomes the accepted key state. A lock input can silence reporting. A second input chooses whether events still come out while the lock is on.

Top module: `kpd_matrix_scan`

## Requirements
- R1: Pin i < NROW is row i and pin NROW+c is column c. A pin outside the matrix has `pin_oe` = `gpo_dir[i]` and `pin_do` = `gpo_val[i]`, one cycle after these inputs change. Its `gpi_val[i]` shows `pin_in[i]` through two flops. `gpi_val` reads 0 for matrix pins.
- R2: While `rst_n` is low, `pin_oe` is all zero and `ev_valid` is 0, whatever the configuration inputs are. After reset every pin is an input until its configuration register is loaded.
- R3: Matrix columns are driven (`pin_oe`=1, `pin_do`=0) one at a time, in ascending column order, each for DWELL_US microseconds of clock cycles (minimum 4), wrapping to the lowest column. A column outside the matrix is never driven by the scan.
- R4: At most one matrix column is driven low in any cycle.
- R5: The key code is row*NCOL + column + 1. With 8x10 this gives 1..80 in `ev_code`. `ev_press` is 1 for a press and 0 for a release.
- R6: Each accepted press produces exactly one event, and each accepted release produces exactly one event, as a single-cycle `ev_valid` pulse.
- R7: A key change is reported no earlier than DEB_US microseconds of cycles after it appears on the pins. A key that bounces with intervals shorter than that gives no event until it settles, and then one event for its final state.
- R8: While `lock` = 1 and `lock_keep_ev` = 0, no event is emitted. Changes in that period are absorbed and are not reported after unlock. With `lock_keep_ev` = 1, events continue while locked.
- R9: A row outside the matrix never produces key events, and a matrix row pin is never driven.
- R10: Key changes accepted together are reported in ascending key-code order, one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| row_en | input | NROW | Row i belongs to the matrix |
| col_en | input | NCOL | Column c belongs to the matrix |
| gpo_dir | input | NROW+NCOL | Output enable for pins outside the matrix |
| gpo_val | input | NROW+NCOL | Output level for pins outside the matrix |
| lock | input | 1 | Keypad lock |
| lock_keep_ev | input | 1 | Keep reporting events while locked |
| pin_in | input | NROW+NCOL | Pin levels seen at the pads |
| pin_oe | output | NROW+NCOL | Pad output enable |
| pin_do | output | NROW+NCOL | Pad output level |
| gpi_val | output | NROW+NCOL | Synchronised input level of pins outside the matrix |
| ev_valid | output | 1 | One-cycle event strobe |
| ev_code | output | $clog2(NROW*NCOL+1) | Key code of the event |
| ev_press | output | 1 | 1 = press, 0 = release |

## Verification
The hardest state to reach is a key that keeps changing for longer than the debounce window and then settles. Every scan frame in that period must reset the stability timer, and only the final level may produce an event. The bench models the matrix as switches between driven columns and pulled-up rows, so every row level follows the design's own column drive. It toggles one key every 100 cycles, which is shorter than the 275-cycle window at the bench's `CLK_HZ`. It checks that no event appears during the bouncing, then that exactly one press follows, and it measures how many cycles each accepted event took.

// File: rtl/kpd_matrix_scan.sv
module kpd_matrix_scan #(
  parameter int NROW     = 8,
  parameter int NCOL     = 10,
  parameter int CLK_HZ   = 125_000_000,
  parameter int DEB_US   = 275,
  parameter int DWELL_US = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NROW-1:0]                row_en,
  input  logic [NCOL-1:0]                col_en,
  input  logic [NROW+NCOL-1:0]           gpo_dir,
  input  logic [NROW+NCOL-1:0]           gpo_val,
  input  logic                           lock,
  input  logic                           lock_keep_ev,
  input  logic [NROW+NCOL-1:0]           pin_in,
  output logic [NROW+NCOL-1:0]           pin_oe,
  output logic [NROW+NCOL-1:0]           pin_do,
  output logic [NROW+NCOL-1:0]           gpi_val,
  output logic                           ev_valid,
  output logic [$clog2(NROW*NCOL+1)-1:0] ev_code,
  output logic                           ev_press
);
  localparam int NPIN    = NROW + NCOL;
  localparam int NKEY    = NROW * NCOL;
  localparam int KW      = $clog2(NKEY + 1);
  localparam int CW      = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int CYC_US  = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int DEB_CYC = CYC_US * DEB_US;
  localparam int DWELL   = (CYC_US * DWELL_US < 4) ? 4 : CYC_US * DWELL_US;
  localparam int DW      = $clog2(DWELL + 1);
  localparam int SW      = $clog2(DEB_CYC + 1);

  logic [NROW-1:0] row_cfg;
  logic [NCOL-1:0] col_cfg;
  logic [NPIN-1:0] dir_q, val_q, sync1, sync2;
  logic [CW-1:0]   col_idx;
  logic [DW-1:0]   dwell_cnt;
  logic [SW-1:0]   stab_cnt;
  logic [NKEY-1:0] frame, nf, last_frame, stable, reported;
  logic [KW-1:0]   pick;
  logic            hit;

  wire dwell_last = (dwell_cnt == DW'(DWELL - 1));
  wire col_last   = (col_idx == CW'(NCOL - 1));
  wire frame_end  = dwell_last && col_last;
  wire quiet      = lock && !lock_keep_ev;
  wire [NKEY-1:0] diff = stable ^ reported;

  assign gpi_val = sync2 & ~{col_cfg, row_cfg};

  for (genvar r = 0; r < NROW; r++) begin : g_row
    assign pin_oe[r] = dir_q[r] & ~row_cfg[r];
    assign pin_do[r] = val_q[r];
  end
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign pin_oe[NROW+c] = col_cfg[c] ? (col_idx == CW'(c)) : dir_q[NROW+c];
    assign pin_do[NROW+c] = col_cfg[c] ? 1'b0 : val_q[NROW+c];
  end

  always_comb begin
    nf = frame;
    for (int r = 0; r < NROW; r++)
      nf[r*NCOL + int'(col_idx)] = row_cfg[r] & col_cfg[col_idx] & ~sync2[r];
  end

  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = NKEY - 1; i >= 0; i--)
      if (diff[i]) begin
        hit  = 1'b1;
        pick = KW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_cfg <= '0;
      col_cfg <= '0;
      dir_q   <= '0;
      val_q   <= '0;
      sync1   <= '1;
      sync2   <= '1;
    end else begin
      row_cfg <= row_en;
      col_cfg <= col_en;
      dir_q   <= gpo_dir;
      val_q   <= gpo_val;
      sync1   <= pin_in;
      sync2   <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_idx   <= '0;
      dwell_cnt <= '0;
      frame     <= '0;
    end else if (dwell_last) begin
      dwell_cnt <= '0;
      frame     <= nf;
      col_idx   <= col_last ? '0 : col_idx + 1'b1;
    end else begin
      dwell_cnt <= dwell_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_frame <= '0;
      stable     <= '0;
      stab_cnt   <= '0;
    end else if (frame_end && nf != last_frame) begin
      last_frame <= nf;
      stab_cnt   <= '0;
    end else begin
      if (stab_cnt != SW'(DEB_CYC)) stab_cnt <= stab_cnt + 1'b1;
      if (frame_end && stab_cnt == SW'(DEB_CYC)) stable <= last_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reported <= '0;
      ev_valid <= 1'b0;
      ev_code  <= '0;
      ev_press <= 1'b0;
    end else begin
      ev_valid <= hit && !quiet;
      if (hit) begin
        reported[pick] <= stable[pick];
        ev_code        <= pick + 1'b1;
        ev_press       <= stable[pick];
      end
    end
  end
endmodule

module kpd_matrix_scan_chk #(
  parameter int NROW = 8,
  parameter int NCOL = 10
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           lock,
  input logic                           lock_keep_ev,
  input logic [NROW+NCOL-1:0]           pin_oe,
  input logic [NROW+NCOL-1:0]           pin_do,
  input logic [NROW-1:0]                row_cfg,
  input logic [NCOL-1:0]                col_cfg,
  input logic                           ev_valid,
  input logic [$clog2(NROW*NCOL+1)-1:0] ev_code
);
  a_r4_one_column: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pin_oe[NROW+NCOL-1:NROW] & ~pin_do[NROW+NCOL-1:NROW] & col_cfg));

  a_r9_rows_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[NROW-1:0] & row_cfg) == '0);

  a_r5_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (ev_code != '0 && int'(ev_code) <= NROW*NCOL));

  a_r8_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !lock_keep_ev) |=> !ev_valid);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> !(ev_valid && ev_code == $past(ev_code)));
endmodule

bind kpd_matrix_scan kpd_matrix_scan_chk #(.NROW(NROW), .NCOL(NCOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock(lock), .lock_keep_ev(lock_keep_ev),
  .pin_oe(pin_oe), .pin_do(pin_do), .row_cfg(row_cfg), .col_cfg(col_cfg),
  .ev_valid(ev_valid), .ev_code(ev_code)
);

// File: tb/kpd_matrix_scan_test.sv
`timescale 1ns/1ps
module kpd_matrix_scan_test;
  localparam int NROW = 8, NCOL = 10, NPIN = 18;
  localparam int DEB = 275;

  logic clk = 0, rst_n = 0;
  logic [NROW-1:0] row_en = '1;
  logic [NCOL-1:0] col_en = '1;
  logic [NPIN-1:0] gpo_dir = '1, gpo_val = '0, ext_low = '0, pin_in;
  logic lock = 0, lock_keep_ev = 0;
  logic [NPIN-1:0] pin_oe, pin_do, gpi_val;
  logic ev_valid, ev_press;
  logic [6:0] ev_code;
  logic [NROW-1:0][NCOL-1:0] kp = '0;
  logic [NCOL-1:0] drv;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kpd_matrix_scan #(.CLK_HZ(1_000_000), .DEB_US(DEB), .DWELL_US(4)) uut (
    .clk(clk), .rst_n(rst_n), .row_en(row_en), .col_en(col_en),
    .gpo_dir(gpo_dir), .gpo_val(gpo_val), .lock(lock), .lock_keep_ev(lock_keep_ev),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_do(pin_do), .gpi_val(gpi_val),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_press(ev_press));

  always_comb begin
    for (int c = 0; c < NCOL; c++) drv[c] = pin_oe[NROW+c] & ~pin_do[NROW+c];
    for (int r = 0; r < NROW; r++) pin_in[r] = ext_low[r] ? 1'b0 : ~|(kp[r] & drv);
    for (int c = 0; c < NCOL; c++)
      pin_in[NROW+c] = ext_low[NROW+c] ? 1'b0 : (pin_oe[NROW+c] ? pin_do[NROW+c] : 1'b1);
  end

  // {row, col, expected code}
  localparam logic [15:0] VEC [6] = '{
    {4'd0, 4'd0, 8'd1}, {4'd0, 4'd9, 8'd10}, {4'd7, 4'd0, 8'd71},
    {4'd7, 4'd9, 8'd80}, {4'd3, 4'd4, 8'd35}, {4'd5, 4'd1, 8'd52}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ev(input int maxc, output bit got, output int code,
                         output bit press, output int lat);
    got = 0; code = 0; press = 0; lat = 0;
    for (int k = 1; k <= maxc; k++) begin
      @(negedge clk);
      if (ev_valid) begin
        got = 1; code = int'(ev_code); press = ev_press; lat = k;
        return;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit got, pr;
    int code, lat, cnt, prev, cur, bad;
    repeat (3) @(negedge clk);
    chk(pin_oe == '0, "R2 oe in reset", int'(pin_oe), 0);
    chk(ev_valid == 0, "R2 ev in reset", ev_valid, 0);
    gpo_dir = '0;
    rst_n = 1;
    repeat (50) @(negedge clk);

    foreach (VEC[i]) begin
      int r = VEC[i][15:12], c = VEC[i][11:8], e = VEC[i][7:0];
      kp[r][c] = 1;
      wait_ev(900, got, code, pr, lat);
      chk(got && code == e, "R5 press code", code, e);
      chk(pr == 1, "R6 press flag", pr, 1);
      chk(lat >= DEB, "R7 press latency", lat, DEB);
      kp[r][c] = 0;
      wait_ev(900, got, code, pr, lat);
      chk(got && code == e && pr == 0, "R6 release event", code, e);
    end

    cnt = 0; bad = 0; prev = -1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if ($countones(drv) > 1) bad++;
      cur = -1;
      for (int c = 0; c < NCOL; c++) if (drv[c]) cur = c;
      if (cur == 3) cnt++;
      if (prev >= 0 && cur != prev && cur != (prev + 1) % NCOL) bad++;
      prev = cur;
    end
    chk(bad == 0, "R4 R3 ascending single drive", bad, 0);
    chk(cnt == 8, "R3 dwell cycles", cnt, 8);

    col_en[9] = 0; gpo_dir[17] = 0;
    cnt = 0;
    kp[0][9] = 1;
    for (int k = 0; k < 80; k++) begin @(negedge clk); if (pin_oe[17]) cnt++; end
    chk(cnt == 0, "R3 unconfigured column idle", cnt, 0);
    wait_ev(800, got, code, pr, lat);
    chk(!got, "R3 no event on excluded column", code, 0);
    kp[0][9] = 0;
    gpo_dir[17] = 1; gpo_val[17] = 1;
    @(negedge clk);
    chk(pin_oe[17] && pin_do[17], "R1 gpo drive", {pin_oe[17], pin_do[17]}, 3);
    col_en[9] = 1; gpo_dir[17] = 0; gpo_val[17] = 0;

    row_en[6] = 0; ext_low[6] = 1;
    repeat (3) @(negedge clk);
    chk(gpi_val[6] == 0, "R1 gpi low", gpi_val[6], 0);
    ext_low[6] = 0;
    repeat (3) @(negedge clk);
    chk(gpi_val[6] == 1, "R1 gpi high", gpi_val[6], 1);
    chk(gpi_val[0] == 0, "R1 matrix pin reads 0", gpi_val[0], 0);
    row_en[6] = 1;

    row_en[7] = 0;
    kp[7][3] = 1;
    wait_ev(800, got, code, pr, lat);
    chk(!got, "R9 excluded row silent", code, 0);
    kp[7][3] = 0;
    repeat (100) @(negedge clk);
    row_en[7] = 1;
    repeat (800) @(negedge clk);

    lock = 1; lock_keep_ev = 0;
    kp[1][1] = 1;
    wait_ev(800, got, code, pr, lat);
    chk(!got, "R8 locked press silent", code, 0);
    lock = 0;
    wait_ev(800, got, code, pr, lat);
    chk(!got, "R8 absorbed change", code, 0);
    kp[1][1] = 0;
    wait_ev(900, got, code, pr, lat);
    chk(got && code == 12 && pr == 0, "R8 release after unlock", code, 12);
    lock = 1; lock_keep_ev = 1;
    kp[2][2] = 1;
    wait_ev(900, got, code, pr, lat);
    chk(got && code == 23 && pr == 1, "R8 keep events while locked", code, 23);
    kp[2][2] = 0;
    wait_ev(900, got, code, pr, lat);
    lock = 0; lock_keep_ev = 0;

    kp[4][6] = 1; kp[1][2] = 1;
    wait_ev(900, got, code, pr, lat);
    chk(got && code == 13, "R10 first of pair", code, 13);
    @(negedge clk);
    chk(ev_valid && ev_code == 47, "R10 second of pair", int'(ev_code), 47);
    kp[4][6] = 0; kp[1][2] = 0;
    repeat (900) @(negedge clk);

    cnt = 0;
    for (int t = 0; t < 7; t++) begin
      kp[2][5] = ~kp[2][5];
      for (int k = 0; k < 100; k++) begin @(negedge clk); if (ev_valid) cnt++; end
    end
    chk(cnt == 0, "R7 bounce silent", cnt, 0);
    wait_ev(900, got, code, pr, lat);
    chk(got && code == 26 && pr == 1, "R7 settled press", code, 26);
    wait_ev(800, got, code, pr, lat);
    chk(!got, "R6 single event after bounce", code, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule